// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block checks the integrity of a 64-bit device identifier that arrives one bit per strobe from a single-wire serial bus front end. The first 56 bits form the identifier body: an 8-bit family code followed by a 48-bit serial number, each sent least significant bit first. The block feeds them through a bit-serial CRC-8 register. The last 8 bits carry the CRC byte that the sender computed. The block captures this byte and compares it with its own result.

When the 64th bit has been taken, the block raises a one-cycle completion pulse. It then holds either a pass flag or a fail flag until the next start strobe. A command sequencer watches the fail flag and refuses to issue further commands while it is set. A start strobe restarts the check at any time and discards any partial sequence.

Top module: `romid_crc_check`

## Requirements
- R1: After synchronous reset, `crc_q` is 0 and `done`, `match` and `fail` are all low. The block is then ready to take the first identifier bit.
- R2: Each accepted data bit among the first 56 updates the CRC, starting from an all-zero register. The update computes feedback = bit XOR `crc_q[0]`, shifts the register right by one, and XORs 0x8C (reflected x^8+x^5+x^4+1) into it when the feedback is 1. After 56 bits, `crc_q` equals the CRC of the identifier taken LSB first.
- R3: In a cycle where `bit_vld` is low, the block state does not change, so idle gaps between bits do not alter the result.
- R4: Accepted bits 57 to 64 are shifted LSB first into a separate received-byte register, and `crc_q` keeps its value.
- R5: `done` is high for exactly one cycle, in the cycle right after the edge that accepts the 64th bit.
- R6: When `done` rises, `match` is high if the received byte equals `crc_q`. `match` then stays high until a start strobe.
- R7: When `done` rises, `fail` is high if the received byte differs from `crc_q`. `fail` then stays high until a start strobe. `match` and `fail` are never high together.
- R8: A start strobe clears `crc_q`, the bit count and both flags, and aborts any partial sequence. If `bit_vld` is high in the same cycle as `start`, that bit is dropped.
- R9: After the 64th bit, further bit strobes are ignored until a start strobe. `crc_q`, `match` and `fail` keep their values and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Restart strobe; clears the state and aborts any sequence |
| bit_vld | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Serial data bit |
| crc_q | output | 8 | Running CRC register |
| done | output | 1 | One-cycle pulse after the 64th bit |
| match | output | 1 | Held high when the received CRC byte agrees |
| fail | output | 1 | Held high when the received CRC byte disagrees |

## Verification
Random 56-bit identifiers are sent with the CRC byte computed by the bench. Each is then sent again with one bit of the trailing byte flipped. This separates a correct CRC datapath and comparison from one that would pass or fail regardless of the data. The same identifiers are also sent with random idle gaps between strobes, which exposes any state change on cycles where `bit_vld` is low. Three further patterns check control behaviour. A sequence aborted midway by a start strobe tests the clear. A start strobe that arrives together with a 1 bit tests the drop of that bit. Extra strobes sent after completion test that the final result is frozen.

// File: rtl/romid_crc_check.sv
module romid_crc_check #(
  parameter int ID_BITS = 56,
  parameter int CRC_W   = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_q,
  output logic             done,
  output logic             match,
  output logic             fail
);
  localparam int TOTAL = ID_BITS + CRC_W;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] cnt;
  logic [CRC_W-1:0] rx_q;
  logic [CRC_W-1:0] rx_nxt;
  logic [CRC_W-1:0] crc_nxt;
  logic             fin;
  logic             take;
  logic             fb;

  assign fin     = (cnt == CNT_W'(TOTAL));
  assign take    = bit_vld && !fin;
  assign fb      = bit_in ^ crc_q[0];
  assign crc_nxt = (crc_q >> 1) ^ (fb ? POLY_REFL : '0);
  assign rx_nxt  = {bit_in, rx_q[CRC_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt   <= '0;
      crc_q <= '0;
      rx_q  <= '0;
      done  <= 1'b0;
      match <= 1'b0;
      fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        cnt <= cnt + 1'b1;
        if (cnt < CNT_W'(ID_BITS))
          crc_q <= crc_nxt;
        else
          rx_q <= rx_nxt;
        if (cnt == CNT_W'(TOTAL - 1)) begin
          done  <= 1'b1;
          match <= (rx_nxt == crc_q);
          fail  <= (rx_nxt != crc_q);
        end
      end
    end
  end
endmodule

module romid_crc_check_chk #(
  parameter int CRC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             fin,
  input logic [CRC_W-1:0] crc_q,
  input logic             done,
  input logic             match,
  input logic             fail
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst) !(match && fail));
  // R6
  verdict_at_done_chk: assert property (@(posedge clk) disable iff (rst) done |-> (match != fail));
  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (crc_q == '0 && !match && !fail && !done));
  // R9
  frozen_after_fin_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && !start) |=> ($stable(crc_q) && $stable(match) && $stable(fail) && !done));
endmodule

bind romid_crc_check romid_crc_check_chk #(.CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .fin(fin),
  .crc_q(crc_q), .done(done), .match(match), .fail(fail)
);

// File: tb/romid_crc_check_tb.sv
`timescale 1ns/1ps
module romid_crc_check_tb;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic [7:0] crc_q;
  logic done, match, fail;
  int checks = 0, errors = 0;

  romid_crc_check u_dut (.clk(clk), .rst(rst), .start(start), .bit_vld(bit_vld),
    .bit_in(bit_in), .crc_q(crc_q), .done(done), .match(match), .fail(fail));

  always #4 clk = ~clk;

  function automatic logic [7:0] ref_crc(input logic [55:0] id);
    logic [7:0] c = '0;
    for (int i = 0; i < 56; i++) begin
      logic f = id[i] ^ c[0];
      c = (c >> 1) ^ (f ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    bit_vld = 1'b1; bit_in = b;
    @(negedge clk);
    bit_vld = 1'b0; bit_in = 1'b0;
  endtask

  task automatic restart();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic run_id(input logic [55:0] id, input logic [7:0] rxb, input bit gaps);
    logic [7:0] c = ref_crc(id);
    restart();
    for (int i = 0; i < 56; i++) send_bit(id[i], gaps ? int'($urandom_range(0, 3)) : 0);
    chk("R2 crc after 56 bits", crc_q, c);
    for (int i = 0; i < 7; i++) send_bit(rxb[i], gaps ? int'($urandom_range(0, 2)) : 0);
    chk("R4 crc held during byte", crc_q, c);
    chk("R5 no early done", done, 0);
    send_bit(rxb[7], 0);
    chk("R5 done pulse", done, 1);
    chk("R6 match", match, rxb == c);
    chk("R7 fail", fail, rxb != c);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    chk("R6 match held", match, rxb == c);
    chk("R7 fail held", fail, rxb != c);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 crc", crc_q, 0);
    chk("R1 flags", {done, match, fail}, 0);
  endtask

  task automatic t_random(input bit gaps);
    for (int n = 0; n < 6; n++) begin
      logic [55:0] id = {$urandom, $urandom};
      logic [7:0] c = ref_crc(id);
      run_id(id, c, gaps);
      run_id(id, c ^ (8'h01 << $urandom_range(0, 7)), gaps);
    end
  endtask

  task automatic t_abort();
    logic [55:0] id = {$urandom, $urandom};
    restart();
    for (int i = 0; i < 20; i++) send_bit(1'b1, 0);
    restart();
    chk("R8 crc cleared", crc_q, 0);
    run_id(id, ref_crc(id), 0);
    start = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    start = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    chk("R8 bit dropped with start", crc_q, 0);
    chk("R8 flags cleared", {match, fail}, 0);
    @(negedge clk);
    chk("R3 idle cycle no change", crc_q, 0);
    send_bit(1'b1, 0);
    chk("R2 first bit", crc_q, 8'h8C);
  endtask

  task automatic t_after_done();
    logic [55:0] id = {$urandom, $urandom};
    logic [7:0] c = ref_crc(id);
    run_id(id, c, 0);
    for (int i = 0; i < 5; i++) begin
      send_bit(1'b1, 0);
      chk("R9 done stays low", done, 0);
    end
    chk("R9 crc frozen", crc_q, c);
    chk("R9 match frozen", {match, fail}, 2'b10);
  endtask

  initial begin
    t_reset();
    t_random(1'b0);
    t_random(1'b1);
    t_abort();
    t_after_done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule